// File: doc/BRIEF.md
# Serial Port Clock and Frame-Sync Generator

This block produces the bit clock and a periodic frame-sync for a synchronous serial port. Everything runs on the core clock. In internal mode a counter divides the core clock by eight times one plus a 15-bit divisor and gives a square-wave bit clock. In external mode a bit clock from a pin is brought into the core domain through a two-stage synchronizer and then forwarded. With either source, the rising bit-clock edges drive a frame counter. That counter raises a frame-sync every one-plus-divisor bit clocks and holds it for one full bit period. Serial transfers can then repeat without software acting on each frame.

The shifter that uses these outputs gets one-core-cycle strobes that mark each rising and falling bit-clock edge. The block has no data path, so there is no valid/ready stream. All pins are plain control and status levels, and nothing at the edge can apply back-pressure. Both divisors are latched as shadow copies. A new value therefore never cuts a clock phase or a frame short.

Top module: `sclk_fsync_gen`

## Requirements
- R1: While `rst_n` or `enable` is low, `sclk_out`, `fsync_out`, `sclk_rise` and `sclk_fall` are all 0 and both counters restart from zero. The latched divisors follow the inputs during this time.
- R2: In internal mode (`ext_sel` = 0), every high phase and every low phase of `sclk_out` lasts exactly 4 × (`clk_div` + 1) core cycles. With `clk_div` = 0 the full period is 8 core cycles.
- R3: A change on `clk_div` takes effect only at the next `sclk_out` transition. Each phase uses the value of `clk_div` present at the core edge where that phase began.
- R4: After enable, `fsync_out` rises together with the (`fs_div` + 1)-th rising edge of `sclk_out`, and again every `fs_div` + 1 rising edges after that. It stays high from that rising edge until the next rising edge, which is one bit period.
- R5: With `fs_div` = 0, a frame-sync starts on every rising edge of `sclk_out`, so `fsync_out` stays high while the block runs.
- R6: A change on `fs_div` takes effect only at the rising edge where the frame counter wraps. The frame in progress keeps its old length.
- R7: In external mode (`ext_sel` = 1), `sclk_out` equals `ext_sclk` as sampled three core edges earlier: two synchronizer stages and one output register. Frame counting uses these forwarded edges exactly as it uses internal ones.
- R8: `sclk_rise` is high for exactly the one core cycle in which `sclk_out` first reads 1 after being 0. `sclk_fall` does the same for the first cycle in which it reads 0 after being 1.
- R9: `sclk_rise` and `sclk_fall` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds it idle |
| ext_sel | input | 1 | 0 = internal divided clock, 1 = external bit clock; change only while disabled |
| ext_sclk | input | 1 | External bit clock, no faster than core clock / 8 |
| clk_div | input | 15 | Bit-clock divisor; period = 8 × (clk_div + 1) core cycles |
| fs_div | input | 16 | Frame divisor, unsigned; fs_div + 1 bit clocks per frame |
| sclk_out | output | 1 | Serial bit clock |
| fsync_out | output | 1 | Frame-sync, one bit period wide |
| sclk_rise | output | 1 | One-cycle strobe on each rising bit-clock edge |
| sclk_fall | output | 1 | One-cycle strobe on each falling bit-clock edge |

## Verification
The cycle that matters most is the one where the bit-clock edge, the strobe and a frame-counter wrap all happen together, while a divisor load lands on that same edge. The bench causes this by changing `clk_div` and `fs_div` at random cycles in the middle of a run, so a write often falls on the very edge that reloads the shadow copy. A reference model in the bench records which input value was present at each edge. It predicts the length of every phase and the state of `fsync_out` at every rising edge, so a load taken one edge early or late shows up as a wrong phase length or a frame-sync that is out of place.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  // Edge events raised one cycle before the registered bit clock moves
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sfg_int_div.sv
module sfg_int_div
  import sfg_pkg::*;
#(
  parameter int DIV_W    = 15,
  parameter int PRE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output edge_evt_t        evt
);
  localparam int CNT_W = DIV_W + 1 + PRE_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic             phase_q;
  logic             wrap;

  // Half period in core cycles: (div + 1) scaled by the fixed prescale
  function automatic logic [CNT_W-1:0] half_of(input logic [DIV_W-1:0] d);
    logic [CNT_W-1:0] wide;
    wide = {{(CNT_W-DIV_W){1'b0}}, d} + 1'b1;
    return wide << PRE_LOG2;
  endfunction

  assign wrap = run && (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= half_of('0);
      phase_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      half_q  <= half_of(div_in);
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      half_q  <= half_of(div_in);   // shadow load only at a phase boundary
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    evt.rise = wrap & ~phase_q;
    evt.fall = wrap & phase_q;
  end
endmodule

// File: rtl/sfg_ext_sync.sv
module sfg_ext_sync
  import sfg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      pin_in,
  output edge_evt_t evt
);
  // pipe[0..STAGES-1] synchronize, pipe[STAGES] remembers the last value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pipe_q[0] <= 1'b0;
    else if (!run) pipe_q[0] <= 1'b0;
    else           pipe_q[0] <= pin_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pipe_q[i] <= 1'b0;
      else if (!run) pipe_q[i] <= 1'b0;
      else           pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_comb begin
    evt.rise = run & pipe_q[STAGES-1] & ~pipe_q[STAGES];
    evt.fall = run & ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/sfg_fs_count.sv
module sfg_fs_count #(
  parameter int FS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [FS_W-1:0] fs_in,
  output logic            fsync
);
  logic [FS_W-1:0] cnt_q;
  logic [FS_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      fsync <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      lim_q <= fs_in;
      fsync <= 1'b0;
    end else if (tick) begin
      if (cnt_q == lim_q) begin
        cnt_q <= '0;
        lim_q <= fs_in;       // new frame length only at the wrap
        fsync <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        fsync <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sclk_fsync_gen.sv
module sclk_fsync_gen
  import sfg_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int FS_W        = 16,
  parameter int PRE_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ext_sel,
  input  logic             ext_sclk,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [FS_W-1:0]  fs_div,
  output logic             sclk_out,
  output logic             fsync_out,
  output logic             sclk_rise,
  output logic             sclk_fall
);
  clk_src_e  src;
  edge_evt_t int_evt;
  edge_evt_t ext_evt;
  edge_evt_t sel_evt;
  logic      int_run;
  logic      ext_run;

  assign src     = clk_src_e'(ext_sel);
  assign int_run = enable && (src == SRC_INTERNAL);
  assign ext_run = enable && (src == SRC_EXTERNAL);

  sfg_int_div #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .run(int_run), .div_in(clk_div), .evt(int_evt)
  );

  sfg_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .run(ext_run), .pin_in(ext_sclk), .evt(ext_evt)
  );

  always_comb sel_evt = (src == SRC_EXTERNAL) ? ext_evt : int_evt;

  sfg_fs_count #(.FS_W(FS_W)) u_fs (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(sel_evt.rise),
    .fs_in(fs_div), .fsync(fsync_out)
  );

  // Output stage: bit clock and strobes move on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_out  <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else if (!enable) begin
      sclk_out  <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else begin
      sclk_rise <= sel_evt.rise;
      sclk_fall <= sel_evt.fall;
      if (sel_evt.rise)      sclk_out <= 1'b1;
      else if (sel_evt.fall) sclk_out <= 1'b0;
    end
  end
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int DIV_W = 15,
  parameter int FS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             ext_sel,
  input logic [DIV_W-1:0] clk_div,
  input logic [FS_W-1:0]  fs_div,
  input logic             sclk_out,
  input logic             fsync_out,
  input logic             sclk_rise,
  input logic             sclk_fall
);
  logic [3:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!enable) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sclk_rise || sclk_fall) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 4'hF) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sclk_out && !fsync_out && !sclk_rise && !sclk_fall));

  assert_rise_marks_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> (sclk_out && !$past(sclk_out)));

  assert_fall_marks_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |-> (!sclk_out && $past(sclk_out)));

  assert_edges_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sclk_fall));

  assert_fsync_moves_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(fsync_out)) |-> sclk_rise);

  // R2: an internal phase is never shorter than four core cycles
  assert_min_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !ext_sel && seen_q && (sclk_rise || sclk_fall)) |-> (gap_q >= 4'd3));
endmodule

bind sclk_fsync_gen sfg_checker #(.DIV_W(DIV_W), .FS_W(FS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
  .clk_div(clk_div), .fs_div(fs_div), .sclk_out(sclk_out),
  .fsync_out(fsync_out), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
);

// File: tb/sclk_fsync_gen_tb_top.sv
module sclk_fsync_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        ext_sel = 1'b0;
  logic        ext_sclk = 1'b0;
  logic [14:0] clk_div = '0;
  logic [15:0] fs_div = '0;
  logic        sclk_out, fsync_out, sclk_rise, sclk_fall;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_fsync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ext_sel(ext_sel),
    .ext_sclk(ext_sclk), .clk_div(clk_div), .fs_div(fs_div),
    .sclk_out(sclk_out), .fsync_out(fsync_out),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int half_len(input int d);
    return 4 * (d + 1);
  endfunction

  // Input values seen by the design at the last rising edge
  logic [14:0] div_e;
  logic [15:0] fs_e;
  logic        en_e, sel_e;
  logic [2:0]  hist;
  always @(posedge clk) begin
    div_e <= clk_div;
    fs_e  <= fs_div;
    en_e  <= enable && rst_n;
    sel_e <= ext_sel;
    hist  <= (enable && rst_n) ? {hist[1:0], ext_sclk} : 3'b000;
  end

  bit div_changed = 0;
  bit fs_changed  = 0;
  bit prev_s = 0, started = 0, exp_fs = 0;
  int cyc = 0, exp_half = 0, mcnt = 0, mfs = 0;

  always @(negedge clk) begin
    if (!en_e) begin
      chk(!sclk_out && !fsync_out && !sclk_rise && !sclk_fall, "R1",
          "idle outputs", {sclk_out, fsync_out, sclk_rise, sclk_fall}, 0);
      mcnt = 0; mfs = fs_e; exp_fs = 0; started = 0; prev_s = 0; cyc = 0;
    end else begin
      bit rose, fell;
      string rq;
      rose = sclk_out && !prev_s;
      fell = !sclk_out && prev_s;
      chk(sclk_rise == rose, "R8", "rise strobe", sclk_rise, rose);
      chk(sclk_fall == fell, "R8", "fall strobe", sclk_fall, fell);
      if (sel_e) begin
        chk(sclk_out == hist[2], "R7", "forwarded clock", sclk_out, hist[2]);
      end else begin
        cyc++;
        if (rose || fell) begin
          rq = div_changed ? "R3" : "R2";
          if (started) chk(cyc == exp_half, rq, "phase length", cyc, exp_half);
          started = 1; cyc = 0; exp_half = half_len(div_e);
        end
      end
      if (rose) begin
        if (mcnt == mfs) begin exp_fs = 1; mcnt = 0; mfs = fs_e; end
        else begin exp_fs = 0; mcnt++; end
      end
      rq = (mfs == 0 && exp_fs) ? "R5" : (fs_changed ? "R6" : "R4");
      chk(fsync_out == exp_fs, rq, "frame sync", fsync_out, exp_fs);
      prev_s = sclk_out;
    end
  end

  task automatic run_cycles(input int n, input bit mid_change);
    int at;
    at = $urandom_range(n - 1, 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mid_change && i == at) begin
        clk_div = 15'($urandom_range(3, 0)); div_changed = 1;
        fs_div  = 16'($urandom_range(5, 0)); fs_changed = 1;
      end
    end
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    enable = 0; div_changed = 0; fs_changed = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(!sclk_out && !fsync_out, "R1", "reset state", sclk_out, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 R5: fastest clock, frame-sync every bit
    clk_div = 0; fs_div = 0; enable = 1;
    run_cycles(200, 0);
    go_idle(6);
    // R4: fixed directed frame of three bits
    clk_div = 3; fs_div = 2; enable = 1;
    run_cycles(300, 0);
    go_idle(6);
    // R3 R6: random settings with a change mid-run
    for (int k = 0; k < 10; k++) begin
      clk_div = 15'($urandom_range(3, 0));
      fs_div  = 16'($urandom_range(6, 0));
      enable = 1;
      run_cycles(300, 1);
      go_idle($urandom_range(8, 2));
    end
    // R7: external clock source
    ext_sel = 1; fs_div = 16'd3; enable = 1;
    for (int t = 0; t < 80; t++) begin
      repeat ($urandom_range(9, 4)) @(negedge clk);
      ext_sclk = ~ext_sclk;
      if (t == 40) begin fs_div = 16'd1; fs_changed = 1; end
    end
    repeat (8) @(negedge clk);
    go_idle(6);
    ext_sel = 0; ext_sclk = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule